// File: doc/BRIEF.md
# Dual-Bank Serial Mode-Control Register Target

This block is the serial configuration target for a data converter with eight channels. The channels are split into two fixed groups of four. Each group has its own chip-select input and its own mode register. A host shifts in 16-bit frames that carry a direction flag, a 7-bit register address and a data byte. A write updates the mode register of every group whose select is low. A read shifts the addressed register back out on a pull-down-only serial output.

The serial pins are brought into the system clock domain through synchronizer flops, and the edges of the serial clock are detected there. The mode register supplies four things to the datapath of its group: a bit that disables the clock duty-cycle stabilizer, a bit that enables the output randomizer, an output-format bit, and the power controls. The power controls are decoded into one disable flag per channel and one sleep flag per group. Writing the write-only reset register clears both mode registers and forces both groups into sleep for a short, fixed number of cycles.

Top module: `spi_dual_bank_cfg`

## Requirements
- R1: A frame is 16 bits, sent MSB first, with `sdi` sampled on rising `sck` edges. Frame bit 15 is the direction flag (0 = write, 1 = read), bits 14:8 are the address, and bits 7:0 are the data. The frame takes effect when both selects have returned high.
- R2: A write to address 01h updates group A's register when only `cs_a_n` is low and group B's register when only `cs_b_n` is low. When both selects are low, the write updates both registers.
- R3: For each group g, the mode-register fields appear on the outputs as follows: bit 7 drives `dcs_off[g]`, bit 6 drives `rand_en[g]`, and bit 5 drives `twos_comp[g]`. Index 0 is group A and index 1 is group B.
- R4: Register bit 4 is the group sleep bit and drives `sleep[g]`. Bits 3:0 are per-channel nap bits, and any combination of them is allowed. `chan_off[i]` refers to channel i+1. A channel is off when its group's sleep bit is set or when its own nap bit is set. Group A's nap bits 0, 1, 2 and 3 map to channels 1, 4, 5 and 8. Group B's nap bits 0, 1, 2 and 3 map to channels 2, 3, 6 and 7.
- R5: In a read frame, the addressed register is returned MSB first during the eight data bits. Each bit changes after a falling `sck` edge so that it is valid at the following rising edge. The value comes from group A if `cs_a_n` was low at the first bit, and from group B otherwise. A read leaves both registers unchanged and ignores the data bits on `sdi`.
- R6: `sdo_oe` pulls the line low and is asserted only while a read frame is shifting out a 0. It stays low during write frames, during the header, and while no select is low.
- R7: A frame cut short, with both selects high before 16 rising `sck` edges, changes no register.
- R8: A write to address 00h with data bit 7 set clears both mode registers to 00h, whichever select was used. A write with bit 7 clear has no effect. Reads of 00h return 00h.
- R9: After a reset write completes, `sleep` is 2'b11 for exactly RST_SLEEP_CYC system clock cycles. It then returns to the value held in the registers.
- R10: Writes to any address other than 00h and 01h are ignored, and reads of those addresses return 00h.
- R11: Synchronous active-high `rst` clears both registers, all outputs and any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_a_n | input | 1 | Active-low select for group A |
| cs_b_n | input | 1 | Active-low select for group B |
| sdi | input | 1 | Serial data in |
| sdo_oe | output | 1 | Pull-down enable for the serial data out line |
| dcs_off | output | 2 | Duty-cycle stabilizer disable, one bit per group |
| rand_en | output | 2 | Output randomizer enable, one bit per group |
| twos_comp | output | 2 | Two's complement format select, one bit per group |
| sleep | output | 2 | Group sleep, including the pulse that follows a reset write |
| chan_off | output | 8 | Per-channel disable, bit i = channel i+1 |

## Verification
The assertions check several things on every cycle. A register changes only on a committed write or a clear, and it stays put across reads. A clear leaves zero. A reset write is followed at once by sleep on both groups. A group that is asleep has all four of its channels off. The pull-down never acts while no frame is open. Only the bench's scenarios can show the rest: the full sweep of data values through the field and channel mapping, the bit order and content of read-back, the handling of truncated frames and unmapped addresses, and the exact length of the sleep pulse after a reset.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int N_GRP      = 2;
    localparam int GRP_CH     = 4;
    localparam int N_CH       = N_GRP * GRP_CH;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int HDR_BITS   = FRAME_BITS - DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_SWRST = 7'h00;
    localparam logic [ADDR_W-1:0] ADDR_MODE  = 7'h01;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              dcs_off;
        logic              rand_en;
        logic              twos;
        logic              sleep;
        logic [GRP_CH-1:0] nap;
    } mode_t;

    // Channel index (0-based) driven by a nap bit of a group.
    function automatic int chan_of(input int grp, input int nap_bit);
        int r;
        if (grp == 0) begin
            case (nap_bit)
                0: r = 0;
                1: r = 3;
                2: r = 4;
                default: r = 7;
            endcase
        end else begin
            case (nap_bit)
                0: r = 1;
                1: r = 2;
                2: r = 5;
                default: r = 6;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= raw;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic              tgt_a,
    output logic              tgt_b,
    output frame_t            frame,
    output logic              commit,
    output logic              sdo_oe
);
    logic                  active;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [DATA_W-1:0]     tx;
    logic                  sdo_bit;
    logic                  tx_on;

    assign active   = sel_a | sel_b;
    assign hdr_addr = shreg[ADDR_W-1:0];
    assign frame    = frame_t'(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            sdo_bit <= 1'b1;
            tx_on   <= 1'b0;
            tgt_a   <= 1'b0;
            tgt_b   <= 1'b0;
            commit  <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (!active) begin
                commit  <= (cnt == CNT_W'(FRAME_BITS));
                cnt     <= '0;
                tx_on   <= 1'b0;
                sdo_bit <= 1'b1;
            end else begin
                if (sck_rise && cnt < CNT_W'(FRAME_BITS)) begin
                    shreg <= {shreg[FRAME_BITS-2:0], sdi};
                    cnt   <= cnt + 1'b1;
                    if (cnt == '0) begin
                        tgt_a <= sel_a;
                        tgt_b <= sel_b;
                    end
                end
                if (sck_fall) begin
                    if (cnt == CNT_W'(HDR_BITS)) begin
                        tx_on   <= shreg[ADDR_W];
                        sdo_bit <= rd_byte[DATA_W-1];
                        tx      <= {rd_byte[DATA_W-2:0], 1'b0};
                    end else if (cnt > CNT_W'(HDR_BITS) && cnt < CNT_W'(FRAME_BITS)) begin
                        sdo_bit <= tx[DATA_W-1];
                        tx      <= {tx[DATA_W-2:0], 1'b0};
                    end else if (cnt == CNT_W'(FRAME_BITS)) begin
                        tx_on   <= 1'b0;
                        sdo_bit <= 1'b1;
                    end
                end
            end
        end
    end

    assign sdo_oe = tx_on & ~sdo_bit;

    AST_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active)) |-> !sdo_oe) else $error("tx idle");  // R6

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (wr_en) q <= mode_t'(wr_data);
    end

    AST_BANK_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0)) else $error("bank clr");  // R8
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr_en) |=> $stable(q)) else $error("bank hold");  // R5

endmodule

// File: rtl/chan_map.sv
module chan_map
    import spi_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_t            grp_mode [N_GRP],
    input  logic             force_sleep,
    output logic [N_GRP-1:0] grp_sleep,
    output logic [N_CH-1:0]  chan_off
);
    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            assign grp_sleep[g] = force_sleep | grp_mode[g].sleep;
            for (genvar b = 0; b < GRP_CH; b++) begin : g_ch
                assign chan_off[chan_of(g, b)] = grp_sleep[g] | grp_mode[g].nap[b];

                AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
                    grp_mode[g].sleep |-> chan_off[chan_of(g, b)]) else $error("sleep off");  // R4
            end
        end
    endgenerate
endmodule

// File: rtl/spi_dual_bank_cfg.sv
module spi_dual_bank_cfg
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int RST_SLEEP_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_a_n,
    input  logic       cs_b_n,
    input  logic       sdi,
    output logic       sdo_oe,
    output logic [1:0] dcs_off,
    output logic [1:0] rand_en,
    output logic [1:0] twos_comp,
    output logic [1:0] sleep,
    output logic [7:0] chan_off
);
    localparam int SLP_W = $clog2(RST_SLEEP_CYC + 1);

    logic [3:0]        pins_s;
    logic              sck_s, csa_s, csb_s, sdi_s, sck_d;
    logic              sck_rise, sck_fall;
    logic [ADDR_W-1:0] hdr_addr;
    logic              tgt_a, tgt_b, commit;
    frame_t            frame;
    logic [DATA_W-1:0] rd_byte;
    logic              sw_rst, wr_mode;
    logic [N_GRP-1:0]  wr_en;
    logic [SLP_W-1:0]  slp_cnt;
    mode_t             mode [N_GRP];

    spi_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
        .clk(clk), .rst(rst), .raw({sck, cs_a_n, cs_b_n, sdi}), .synced(pins_s)
    );
    assign {sck_s, csa_s, csb_s, sdi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    spi_frame_rx u_rx (
        .clk(clk), .rst(rst), .sel_a(~csa_s), .sel_b(~csb_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(sdi_s),
        .rd_byte(rd_byte), .hdr_addr(hdr_addr), .tgt_a(tgt_a), .tgt_b(tgt_b),
        .frame(frame), .commit(commit), .sdo_oe(sdo_oe)
    );

    always_comb begin
        rd_byte = '0;
        if (hdr_addr == ADDR_MODE) rd_byte = tgt_a ? mode[0] : mode[1];
    end

    assign sw_rst  = commit && !frame.rd && frame.addr == ADDR_SWRST && frame.data[DATA_W-1];
    assign wr_mode = commit && !frame.rd && frame.addr == ADDR_MODE;
    assign wr_en   = {wr_mode & tgt_b, wr_mode & tgt_a};

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_bank
            cfg_bank u_bank (
                .clk(clk), .rst(rst), .clr(sw_rst), .wr_en(wr_en[g]),
                .wr_data(frame.data), .q(mode[g])
            );
            assign dcs_off[g]   = mode[g].dcs_off;
            assign rand_en[g]   = mode[g].rand_en;
            assign twos_comp[g] = mode[g].twos;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                 slp_cnt <= '0;
        else if (sw_rst)         slp_cnt <= SLP_W'(RST_SLEEP_CYC);
        else if (slp_cnt != '0)  slp_cnt <= slp_cnt - 1'b1;
    end

    chan_map u_map (
        .clk(clk), .rst(rst), .grp_mode(mode), .force_sleep(slp_cnt != '0),
        .grp_sleep(sleep), .chan_off(chan_off)
    );

    AST_WR_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode[0]) |-> $past(wr_en[0] | sw_rst)) else $error("bank A change");  // R2
    AST_SLEEP_ON_SWRST: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (sleep == 2'b11)) else $error("sleep pulse");  // R9

endmodule

// File: tb/spi_dual_bank_cfg_tb.sv
module spi_dual_bank_cfg_tb;
    localparam int HP  = 8;
    localparam int RSC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_a_n = 1'b1, cs_b_n = 1'b1, sdi = 1'b0;
    logic sdo_oe;
    logic [1:0] dcs_off, rand_en, twos_comp, sleep;
    logic [7:0] chan_off;
    logic rd_win = 1'b0;
    int checks = 0, errors = 0, oe_bad = 0;
    logic [7:0] exp_a = 8'h00, exp_b = 8'h00;

    always #5 clk = ~clk;

    spi_dual_bank_cfg #(.SYNC_STAGES(2), .RST_SLEEP_CYC(RSC)) u_dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .sdi(sdi),
        .sdo_oe(sdo_oe), .dcs_off(dcs_off), .rand_en(rand_en), .twos_comp(twos_comp),
        .sleep(sleep), .chan_off(chan_off)
    );

    always @(negedge clk) if (!rst && sdo_oe && !rd_win) oe_bad++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] chan_exp(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        r[0] = a[4] | a[0];  r[3] = a[4] | a[1];  r[4] = a[4] | a[2];  r[7] = a[4] | a[3];
        r[1] = b[4] | b[0];  r[2] = b[4] | b[1];  r[5] = b[4] | b[2];  r[6] = b[4] | b[3];
        return r;
    endfunction

    task automatic chk_outs(input string req);
        chk({req, " dcs_off"},   {30'd0, dcs_off},   {30'd0, exp_b[7], exp_a[7]});
        chk({req, " rand_en"},   {30'd0, rand_en},   {30'd0, exp_b[6], exp_a[6]});
        chk({req, " twos_comp"}, {30'd0, twos_comp}, {30'd0, exp_b[5], exp_a[5]});
        chk({req, " sleep"},     {30'd0, sleep},     {30'd0, exp_b[4], exp_a[4]});
        chk({req, " chan_off"},  {24'd0, chan_off},  {24'd0, chan_exp(exp_a, exp_b)});
    endtask

    // One frame; nbits < 16 truncates. Returns the byte seen on the line.
    task automatic xfer(input logic sa, input logic sb, input logic [15:0] w,
                        input int nbits, input int tail, output logic [7:0] rd);
        rd = '0;
        @(negedge clk);
        cs_a_n = ~sa; cs_b_n = ~sb;
        repeat (HP) @(negedge clk);
        for (int i = 15; i > 15 - nbits; i--) begin
            if (i == 7 && w[15]) rd_win = 1'b1;
            sck = 1'b0; sdi = w[i];
            repeat (HP) @(negedge clk);
            if (i < 8) rd = {rd[6:0], (sdo_oe ? 1'b0 : 1'b1)};
            sck = 1'b1;
            repeat (HP) @(negedge clk);
        end
        sck = 1'b0;
        repeat (HP) @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        repeat (tail) @(negedge clk);
        if (tail > 0) rd_win = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        int cnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk_outs("R11 reset");
        chk("R6 reset oe", {31'd0, sdo_oe}, 32'd0);

        // R1 R2 R3 R4: full sweep on group A
        for (int v = 0; v < 256; v++) begin
            xfer(1'b1, 1'b0, {1'b0, 7'h01, 8'(v)}, 16, 12, rb);
            exp_a = 8'(v);
            chk_outs("R3 R4 sweep A");
        end
        // R2 group B sweep
        for (int v = 0; v < 256; v += 5) begin
            xfer(1'b0, 1'b1, {1'b0, 7'h01, 8'(v)}, 16, 12, rb);
            exp_b = 8'(v);
            chk_outs("R2 R4 sweep B");
        end
        // R2 both selects low write both
        xfer(1'b1, 1'b1, 16'h01_A5, 16, 12, rb);
        exp_a = 8'hA5; exp_b = 8'hA5;
        chk_outs("R2 both");

        // R5 read-back per group, garbage data bits ignored
        for (int v = 0; v < 8; v++) begin
            logic [7:0] va, vb;
            va = 8'(v * 37 + 3); vb = 8'(v * 91 + 200);
            xfer(1'b1, 1'b0, {1'b0, 7'h01, va}, 16, 12, rb);
            xfer(1'b0, 1'b1, {1'b0, 7'h01, vb}, 16, 12, rb);
            exp_a = va; exp_b = vb;
            xfer(1'b1, 1'b0, {1'b1, 7'h01, ~va}, 16, 12, rb);
            chk("R5 read A", {24'd0, rb}, {24'd0, va});
            xfer(1'b0, 1'b1, {1'b1, 7'h01, ~vb}, 16, 12, rb);
            chk("R5 read B", {24'd0, rb}, {24'd0, vb});
            xfer(1'b1, 1'b1, {1'b1, 7'h01, 8'hFF}, 16, 12, rb);
            chk("R5 read both gives A", {24'd0, rb}, {24'd0, va});
            chk_outs("R5 read unchanged");
        end

        // R7 truncated frames
        xfer(1'b1, 1'b0, 16'h01_3C, 15, 12, rb);
        xfer(1'b0, 1'b1, 16'h01_3C, 9, 12, rb);
        chk_outs("R7 truncated");

        // R10 unmapped address
        xfer(1'b1, 1'b1, 16'h05_FF, 16, 12, rb);
        chk_outs("R10 write ignored");
        xfer(1'b1, 1'b0, {1'b1, 7'h05, 8'h00}, 16, 12, rb);
        chk("R10 read unmapped", {24'd0, rb}, 32'd0);

        // R8 reset register
        xfer(1'b1, 1'b0, 16'h00_7F, 16, 12, rb);
        chk_outs("R8 bit7 clear no effect");
        xfer(1'b1, 1'b0, {1'b1, 7'h00, 8'h00}, 16, 12, rb);
        chk("R8 read reset reg", {24'd0, rb}, 32'd0);

        // R9 sleep pulse length, R8 clear of both via select B
        xfer(1'b1, 1'b1, 16'h01_00, 16, 12, rb);
        exp_a = 8'h00; exp_b = 8'h00;
        xfer(1'b1, 1'b1, 16'h01_C3, 16, 12, rb);
        exp_a = 8'hC3; exp_b = 8'hC3;
        xfer(1'b0, 1'b1, 16'h00_80, 16, 0, rb);
        cnt = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (sleep == 2'b11) cnt++;
        end
        chk("R9 sleep pulse cycles", cnt, RSC);
        exp_a = 8'h00; exp_b = 8'h00;
        chk_outs("R8 cleared both");

        // R6 no pull-down outside read data phases
        chk("R6 oe outside read data", oe_bad, 0);

        // R11 reset mid-run
        xfer(1'b1, 1'b1, 16'h01_5A, 16, 12, rb);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        chk_outs("R11 reset mid-run");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule